// File: doc/BRIEF.md
# HDLC Line Framer with Seven-Bit Timeslot Packing

This block turns the payload bytes of one frame into the raw byte stream that a DMA engine copies into a single B-channel timeslot of a TDM line. It builds the frame at bit level. It sends an opening flag, the payload and the 16-bit frame check sequence, with zeros inserted where needed, and then a closing flag. The resulting line bits are packed into bytes for the timeslot. When no frame is in progress, it fills the slot with all-ones idle bytes.

Two packing widths are supported. In full-rate mode every bit of an output byte carries a line bit. In narrow mode only the low seven bits carry line bits and the top bit is always 1, which suits links that steal one bit per octet. The upstream side is a valid/ready byte stream with first-byte and last-byte markers. The downstream side is a valid/ready byte stream, and the engine stalls cleanly while the sink is not ready.

Top module: `hdlc_tx_framer`

## Requirements
- R1: The check sequence is the reflected CRC-16 with polynomial 0x8408, preset to 0xFFFF and run over the payload bytes only. It is complemented and sent low byte first, then high byte. Over the ASCII bytes "123456789" the transmitted value is 0x906E.
- R2: Each byte goes onto the line least significant bit first. Line bits enter an output byte from the top, so the earliest line bit of a byte sits in bit 0.
- R3: After five consecutive 1 bits of payload or check sequence, one 0 bit is inserted. The run counter carries across byte boundaries and into the check sequence, and it is cleared by a data 0 or by an inserted 0. Flags are never stuffed.
- R4: With narrow_mode low, each output byte holds 8 line bits. A frame always starts on an output byte boundary, so its first byte is 0x7E.
- R5: With narrow_mode high, each output byte holds 7 line bits in bits 0..6 and bit 7 is 1. The opening flag is packed the same way, so the first byte of a frame is 0xFE. narrow_mode is taken only while idle, at a byte boundary.
- R6: If the closing flag ends partway through an output byte, the rest of that byte is filled with 1 bits and one whole 0xFF byte follows before the next frame may start. If the closing flag ends on a boundary, the next frame may follow with no gap.
- R7: While no frame is being sent, every output byte is 0xFF in both modes, including the bytes right after reset.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold. No byte is lost or repeated across a stall.
- R9: A byte offered with in_first low while the framer is idle is accepted and discarded. It leaves the output stream unchanged.
- R10: During reset out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow_mode | input | 1 | 1 selects seven line bits per output byte |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte accepted on this edge when in_valid is high |
| in_data | input | 8 | Payload byte |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the last byte of a frame |
| out_valid | output | 1 | Line byte available |
| out_ready | input | 1 | Sink takes the line byte |
| out_data | output | 8 | Packed line byte |

## Verification
Frames are driven in both packing modes with payloads of single bytes, long runs of ones, bytes containing flag patterns and arithmetic ramps. The all-ones payloads separate a correct run counter from one that resets at byte boundaries. The flag-like bytes show that payload flags get stuffed while real flags do not. The "123456789" payload pins down the check sequence and its byte order. Back-to-back frames tell the padded tail with its extra idle byte apart from a flush ending. Random and held sink backpressure, and stray bytes with no first marker, show that stalls and dropped input leave the line stream intact.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 16;
    localparam int STUFF_RUN = 5;
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int IDX_W     = $clog2(BYTE_W + 1);
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int ONES_W    = $clog2(STUFF_RUN + 1);

    localparam logic [BYTE_W-1:0] FLAG_BYTE   = 8'h7E;
    localparam logic [CRC_W-1:0]  CRC_PRESET  = 16'hFFFF;
    localparam logic [CRC_W-1:0]  CRC_POLY_RV = 16'h8408;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPEN,
        ST_FETCH,
        ST_DATA,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_CLOSE,
        ST_PAD,
        ST_EXTRA
    } tx_state_e;

    typedef struct packed {
        tx_state_e            state;
        logic [IDX_W-1:0]     idx;
        logic [ONES_W-1:0]    ones;
        logic                 stuff;
        logic [BYTE_W-1:0]    cur;
        logic                 last;
        logic [CRC_W-1:0]     crc;
        logic                 narrow;
    } seq_t;

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] data;
        logic              valid;
    } pack_t;

endpackage

// File: rtl/hdlc_crc16.sv
module hdlc_crc16
    import hdlc_tx_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    // Reflected byte update, one shift per data bit, LSB first.
    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            if (acc[0] ^ data_in[i]) begin
                acc = (acc >> 1) ^ CRC_POLY_RV;
            end else begin
                acc = acc >> 1;
            end
        end
        crc_out = acc;
    end

endmodule

// File: rtl/hdlc_bit_packer.sv
module hdlc_bit_packer
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              room,
    output logic              boundary,
    output logic              last_slot
);

    pack_t q, d;
    logic [CNT_W-1:0]  width;
    logic [BYTE_W-1:0] sh_n;

    always_comb begin
        width     = narrow ? CNT_W'(BYTE_W - 1) : CNT_W'(BYTE_W);
        room      = !q.valid || out_ready;
        boundary  = (q.cnt == '0);
        last_slot = (q.cnt == width - CNT_W'(1));
        sh_n      = {bit_val, q.sh[BYTE_W-1:1]};
        d         = q;
        if (q.valid && out_ready) begin
            d.valid = 1'b0;
        end
        if (bit_vld) begin
            d.sh = sh_n;
            if (last_slot) begin
                d.cnt   = '0;
                d.valid = 1'b1;
                d.data  = narrow ? {1'b1, sh_n[BYTE_W-1:1]} : sh_n;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sh    <= '0;
            q.cnt   <= '0;
            q.data  <= '1;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.valid;
    assign out_data  = q.data;

    assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_spare_bit_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && narrow) |-> out_data[BYTE_W-1]);

    assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> (!out_valid || out_ready));

    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < width);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data
);

    seq_t q, d;

    logic              bit_vld, bit_val;
    logic              pk_room, pk_boundary, pk_last_slot;
    logic [CRC_W-1:0]  crc_upd;
    logic [ONES_W-1:0] ones_n;
    logic              byte_end;

    hdlc_crc16 u_crc (
        .crc_in  (q.crc),
        .data_in (in_data),
        .crc_out (crc_upd)
    );

    hdlc_bit_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .narrow    (q.narrow),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .room      (pk_room),
        .boundary  (pk_boundary),
        .last_slot (pk_last_slot)
    );

    always_comb begin
        d        = q;
        in_ready = 1'b0;
        bit_vld  = 1'b0;
        bit_val  = 1'b1;
        ones_n   = q.ones;
        byte_end = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                // stray bytes without a start marker are swallowed
                in_ready = !in_first;
                if (pk_boundary && (!out_valid || out_ready)) begin
                    d.narrow = narrow_mode;
                end
                if (pk_room) begin
                    if (pk_boundary && in_valid && in_first) begin
                        d.state = ST_OPEN;
                        d.idx   = '0;
                        d.ones  = '0;
                        d.stuff = 1'b0;
                        d.crc   = CRC_PRESET;
                    end else begin
                        bit_vld = 1'b1;
                        bit_val = 1'b1;
                    end
                end
            end
            ST_OPEN, ST_CLOSE: begin
                if (pk_room) begin
                    bit_vld = 1'b1;
                    bit_val = FLAG_BYTE[q.idx[BIT_W-1:0]];
                    d.idx   = q.idx + IDX_W'(1);
                    if (q.idx == IDX_W'(BYTE_W - 1)) begin
                        d.idx = '0;
                        if (q.state == ST_OPEN) begin
                            d.state = ST_FETCH;
                        end else begin
                            d.state = pk_last_slot ? ST_IDLE : ST_PAD;
                        end
                    end
                end
            end
            ST_FETCH: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.cur   = in_data;
                    d.last  = in_last;
                    d.crc   = crc_upd;
                    d.idx   = '0;
                    d.state = ST_DATA;
                end
            end
            ST_DATA, ST_FCS_LO, ST_FCS_HI: begin
                if (pk_room) begin
                    bit_vld = 1'b1;
                    if (q.stuff) begin
                        bit_val  = 1'b0;
                        d.stuff  = 1'b0;
                        d.ones   = '0;
                        byte_end = (q.idx == IDX_W'(BYTE_W));
                    end else begin
                        bit_val  = q.cur[q.idx[BIT_W-1:0]];
                        d.idx    = q.idx + IDX_W'(1);
                        ones_n   = bit_val ? q.ones + ONES_W'(1) : '0;
                        d.ones   = ones_n;
                        d.stuff  = (ones_n == ONES_W'(STUFF_RUN));
                        byte_end = (q.idx == IDX_W'(BYTE_W - 1)) &&
                                   (ones_n != ONES_W'(STUFF_RUN));
                    end
                    if (byte_end) begin
                        d.idx = '0;
                        if (q.state == ST_DATA) begin
                            if (q.last) begin
                                d.state = ST_FCS_LO;
                                d.cur   = ~q.crc[BYTE_W-1:0];
                            end else begin
                                d.state = ST_FETCH;
                            end
                        end else if (q.state == ST_FCS_LO) begin
                            d.state = ST_FCS_HI;
                            d.cur   = ~q.crc[CRC_W-1:BYTE_W];
                        end else begin
                            d.state = ST_CLOSE;
                        end
                    end
                end
            end
            ST_PAD, ST_EXTRA: begin
                if (pk_room) begin
                    bit_vld = 1'b1;
                    bit_val = 1'b1;
                    if (pk_last_slot) begin
                        d.state = (q.state == ST_PAD) ? ST_EXTRA : ST_IDLE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.idx    <= '0;
            q.ones   <= '0;
            q.stuff  <= 1'b0;
            q.cur    <= '0;
            q.last   <= 1'b0;
            q.crc    <= CRC_PRESET;
            q.narrow <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assert_ones_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.ones <= ONES_W'(STUFF_RUN));

    assert_frame_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_OPEN && q.idx == '0) |-> pk_boundary);

    assert_mode_fixed_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE && $past(q.state) != ST_IDLE) |-> $stable(q.narrow));

    assert_idle_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && bit_vld) |-> bit_val);

endmodule

// File: tb/hdlc_tx_framer_tb.sv
`timescale 1ns/1ps
module hdlc_tx_framer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       narrow_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    hdlc_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // sink model: chooses ready, then records the byte that the next edge takes
    logic [7:0]  got[$];
    int          rd = 0;
    bit          hold = 1'b0;
    bit          bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = hold ? 1'b0 : (bp_en ? lfsr[0] : 1'b1);
        if (rst_n && out_valid && out_ready) got.push_back(out_data);
    end

    // line model built from the requirements
    logic [7:0] exp_q[$];
    logic [7:0] m_sh;
    int         m_cnt, m_w, m_ones;
    bit         m_nar;

    function automatic void m_bit(input logic b);
        m_sh = {b, m_sh[7:1]};
        m_cnt++;
        if (m_cnt == m_w) begin
            exp_q.push_back(m_nar ? {1'b1, m_sh[7:1]} : m_sh);
            m_cnt = 0;
        end
    endfunction

    function automatic void m_flag();
        for (int i = 0; i < 8; i++) m_bit(FLAGV[i]);
    endfunction

    localparam logic [7:0] FLAGV = 8'h7E;

    function automatic void m_stuffed(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            m_bit(v[i]);
            if (v[i]) m_ones++; else m_ones = 0;
            if (m_ones == 5) begin
                m_bit(1'b0);
                m_ones = 0;
            end
        end
    endfunction

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] v);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ v[i]) r = (r >> 1) ^ 16'h8408; else r = r >> 1;
        end
        return r;
    endfunction

    function automatic void build(input bit nar, input logic [7:0] pl[$]);
        logic [15:0] c = 16'hFFFF;
        exp_q.delete();
        m_sh = 8'h00; m_cnt = 0; m_ones = 0; m_nar = nar; m_w = nar ? 7 : 8;
        m_flag();
        foreach (pl[i]) begin
            c = m_crc(c, pl[i]);
            m_stuffed(pl[i]);
        end
        c = ~c;
        m_stuffed(c[7:0]);
        m_stuffed(c[15:8]);
        m_flag();
        if (m_cnt != 0) begin
            while (m_cnt != 0) m_bit(1'b1);
            exp_q.push_back(8'hFF);
        end
    endfunction

    task automatic send_byte(input logic [7:0] v, input logic f, input logic l);
        @(negedge clk);
        in_valid = 1'b1; in_data = v; in_first = f; in_last = l;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] pl[$]);
        foreach (pl[i]) send_byte(pl[i], i == 0, i == pl.size() - 1);
    endtask

    task automatic cmp_frame(input logic [7:0] ex[$], input bit strict, input string req);
        int bad = -1;
        if (!strict) begin
            while (1) begin
                while (got.size() <= rd) @(negedge clk);
                if (got[rd] == 8'hFF) rd++; else break;
            end
        end
        while (got.size() < rd + ex.size()) @(negedge clk);
        foreach (ex[i]) if (bad < 0 && got[rd+i] !== ex[i]) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {bad[15:0], 8'h00, got[rd+bad]}, {bad[15:0], 8'h00, ex[bad]});
        rd += ex.size();
    endtask

    function automatic void make_pl(ref logic [7:0] pl[$], input int len, input logic [7:0] base, input logic [7:0] step);
        pl.delete();
        for (int i = 0; i < len; i++) pl.push_back(base + 8'(i) * step);
    endfunction

    typedef struct packed {
        logic       nar;
        logic [7:0] len;
        logic [7:0] base;
        logic [7:0] step;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd1,  8'h01, 8'h00},   // R2 single bit pattern
        '{1'b0, 8'd4,  8'hFF, 8'h00},   // R3 runs across bytes
        '{1'b0, 8'd5,  8'h1F, 8'h20},   // R3 five-one edges
        '{1'b1, 8'd3,  8'h55, 8'h11},   // R5 narrow packing
        '{1'b1, 8'd6,  8'hFF, 8'h00},   // R3 R5 ones in narrow mode
        '{1'b0, 8'd9,  8'h31, 8'h01},   // R1 check string, full rate
        '{1'b1, 8'd9,  8'h31, 8'h01},   // R1 check string, narrow
        '{1'b0, 8'd16, 8'h7E, 8'h03}    // R3 flag bytes in payload
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] pl[$];
        logic [7:0] ea[$];
        logic [7:0] eb[$];
        logic [15:0] c;
        logic [7:0] cap;
        int n0;
        bit allff;

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid in reset", {31'd0, out_valid}, 0);
        rst_n = 1'b1;
        while (got.size() < 2) @(negedge clk);
        chk(got[0] == 8'hFF && got[1] == 8'hFF, "R7 idle after reset", {got[0], got[1]}, 16'hFFFF);

        // model self-check against the known value
        c = 16'hFFFF;
        for (int i = 0; i < 9; i++) c = m_crc(c, 8'h31 + 8'(i));
        chk(~c == 16'h906E, "R1 check value", ~c, 16'h906E);

        for (int v = 0; v < NVEC; v++) begin
            bp_en = 1'b0;
            narrow_mode = VECS[v].nar;
            repeat (40) @(negedge clk);
            bp_en = v[0];
            make_pl(pl, int'(VECS[v].len), VECS[v].base, VECS[v].step);
            build(VECS[v].nar, pl);
            send_frame(pl);
            cmp_frame(exp_q, 1'b0, VECS[v].nar ? "R5 R3 R1 narrow frame" : "R4 R3 R2 R1 frame");
        end
        bp_en = 1'b0;

        // R7 idle in narrow mode
        repeat (20) @(negedge clk);
        rd = got.size();
        repeat (80) @(negedge clk);
        allff = 1'b1;
        for (int i = rd; i < got.size(); i++) if (got[i] != 8'hFF) allff = 1'b0;
        chk(allff && got.size() > rd + 5, "R7 narrow idle", got.size() - rd, 6);
        rd = got.size();

        // R9 stray bytes while idle
        narrow_mode = 1'b0;
        repeat (40) @(negedge clk);
        n0 = got.size();
        send_byte(8'h00, 1'b0, 1'b0);
        send_byte(8'h7E, 1'b0, 1'b1);
        send_byte(8'h12, 1'b0, 1'b0);
        repeat (60) @(negedge clk);
        allff = 1'b1;
        for (int i = n0; i < got.size(); i++) if (got[i] != 8'hFF) allff = 1'b0;
        chk(allff, "R9 stray bytes ignored", 0, 0);
        make_pl(pl, 3, 8'hC3, 8'h11);
        build(1'b0, pl);
        send_frame(pl);
        cmp_frame(exp_q, 1'b0, "R9 frame after stray bytes");

        // R8 long stall in the middle of a frame
        make_pl(pl, 8, 8'hF0, 8'h07);
        build(1'b0, pl);
        fork
            send_frame(pl);
            begin
                repeat (30) @(negedge clk);
                hold = 1'b1;
                while (!out_valid) @(negedge clk);
                cap = out_data;
                repeat (25) @(negedge clk);
                chk(out_valid && out_data == cap, "R8 hold under stall", {23'd0, out_valid, out_data}, {23'd1, cap});
                hold = 1'b0;
            end
        join
        cmp_frame(exp_q, 1'b0, "R8 no loss across stall");

        // R6 back-to-back frames, both modes
        for (int m = 0; m < 2; m++) begin
            narrow_mode = m[0];
            repeat (40) @(negedge clk);
            make_pl(pl, 2, 8'hA5, 8'h3C);
            build(m[0], pl);
            ea = exp_q;
            send_frame(pl);
            make_pl(pl, 1, 8'h11, 8'h00);
            build(m[0], pl);
            eb = exp_q;
            send_frame(pl);
            cmp_frame(ea, 1'b0, "R6 first of pair");
            cmp_frame(eb, 1'b1, "R6 tail gap before second");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule